// File: doc/BRIEF.md
# Host Mailbox and Interprocessor Interrupt Registers

This block holds two mailbox registers shared between a core and an external host or debug agent, plus a small interprocessor-interrupt control pair, all reached through a single-cycle CSR-style port. The core writes words for the host into the outbound box, and the host drains it by clearing it to zero through its own port. The host places words for the core in the inbound box. Any nonzero word there raises a host interrupt request toward the core's status and trap logic.

An outbound word cannot be overwritten. A core write lands only while the outbound box reads zero, so the host never loses a message it has not yet consumed. Writing the interrupt-clear register sets or drops a local interrupt request from bit 0 of the data. Writing the interrupt-send register emits a one-cycle request that names a target core, and a fabric outside this block delivers it. Both interrupt registers read back as zero.

Top module: `hostmbox_regs`

## Requirements
- R1: After reset both mailboxes read zero, and the host interrupt request, the local interrupt request and the send request valid are all low.
- R2: A core write to the outbound box (address `ADDR_OUTBOX`, default 0x7C0) while it holds zero stores the written data. The value is visible on `csr_rdata` and `host_out_data` from the next cycle.
- R3: A core write to the outbound box while it holds a nonzero value is dropped, and the box keeps its old value.
- R4: `host_out_clr` sets the outbound box to zero on the next edge. This clear takes priority over a core write to the outbound box in the same cycle.
- R5: A core write to the inbound box (address `ADDR_INBOX`, default 0x7C1) stores the data. It raises `irq_host_pend` when the data is nonzero.
- R6: Writing zero to the inbound box clears `irq_host_pend`.
- R7: `host_in_we` loads `host_in_data` into the inbound box with the same interrupt rule. When the host and the core write the inbound box in the same cycle, the host value is kept.
- R8: A core write to the interrupt-clear register (address `ADDR_IPI_CLR`, default 0x7C3) sets `irq_ipi_pend` to bit 0 of the written data from the next cycle.
- R9: Reads of the interrupt-send register (address `ADDR_IPI_SEND`, default 0x7C2) and of the interrupt-clear register return zero.
- R10: Each core write to the interrupt-send register produces exactly one cycle of `ipi_req_valid` in the following cycle. `ipi_req_target` carries the low `TGT_W` bits of the written data. Back-to-back writes give back-to-back pulses.
- R11: An address outside the four registers returns `csr_hit` low and `csr_rdata` zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | ADDR_W | Register address |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Combinational read data |
| csr_hit | output | 1 | Address matches one of the registers |
| host_out_clr | input | 1 | Host drains the outbound box |
| host_out_data | output | DATA_W | Current outbound box value |
| host_in_we | input | 1 | Host loads the inbound box |
| host_in_data | input | DATA_W | Value for the inbound box |
| irq_host_pend | output | 1 | Host interrupt request (inbound box nonzero) |
| irq_ipi_pend | output | 1 | Local interprocessor interrupt request |
| ipi_req_valid | output | 1 | One-cycle send request |
| ipi_req_target | output | TGT_W | Target core index of the send request |

## Verification
On every cycle the assertions check four things. The host interrupt request must agree with the inbound box being nonzero. A full outbound box must hold against core writes, and a host drain must leave it empty. A send request pulse may appear only after a send write, and the two interrupt registers must read as zero. The scenarios in the bench are needed for the rest. They cover the stored data values and the host-versus-core priority on the inbound box. They also cover the masking of the target index, back-to-back send pulses matched against a scoreboard queue, and the proof that writes to unmapped addresses leave the mailboxes untouched.

// File: rtl/hostmbox_pkg.sv
package hostmbox_pkg;
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_OUTBOX,
      SEL_INBOX,
      SEL_IPI_SEND,
      SEL_IPI_CLR
   } reg_sel_e;

   localparam int unsigned NUM_REGS = 4;
endpackage

// File: rtl/hostmbox_decode.sv
module hostmbox_decode
   import hostmbox_pkg::*;
#(
   parameter int unsigned       ADDR_W        = 12,
   parameter logic [ADDR_W-1:0] ADDR_OUTBOX   = 12'h7C0,
   parameter logic [ADDR_W-1:0] ADDR_INBOX    = 12'h7C1,
   parameter logic [ADDR_W-1:0] ADDR_IPI_SEND = 12'h7C2,
   parameter logic [ADDR_W-1:0] ADDR_IPI_CLR  = 12'h7C3
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] MAP [NUM_REGS] =
      '{ADDR_OUTBOX, ADDR_INBOX, ADDR_IPI_SEND, ADDR_IPI_CLR};

   logic [NUM_REGS-1:0] match;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
      assign match[i] = (addr == MAP[i]);
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_uniq
      for (genvar j = i + 1; j < NUM_REGS; j++) begin : g_pair
         if (MAP[i] == MAP[j]) begin : g_dup
            $error("hostmbox_decode: register addresses must be distinct");
         end
      end
   end

   assign hit = |match;

   always_comb begin
      case (match)
         4'b0001: sel = SEL_OUTBOX;
         4'b0010: sel = SEL_INBOX;
         4'b0100: sel = SEL_IPI_SEND;
         4'b1000: sel = SEL_IPI_CLR;
         default: sel = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/hostmbox_outbox.sv
module hostmbox_outbox #(
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic              host_clr,
   output logic [DATA_W-1:0] value
);
   logic empty;
   assign empty = (value == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (host_clr) begin
         value <= '0;
      end else if (core_wr && empty) begin
         value <= core_wdata;
      end
   end
endmodule

// File: rtl/hostmbox_inbox.sv
module hostmbox_inbox #(
   parameter int unsigned DATA_W    = 64,
   parameter bit          HOST_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_wr,
   input  logic [DATA_W-1:0] core_wdata,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] value,
   output logic              pend
);
   logic              take_host;
   logic              do_wr;
   logic [DATA_W-1:0] nxt;

   if (HOST_WINS) begin : g_host_first
      assign take_host = host_wr;
   end else begin : g_core_first
      assign take_host = host_wr && !core_wr;
   end

   assign do_wr = host_wr || core_wr;
   assign nxt   = take_host ? host_wdata : core_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
         pend  <= 1'b0;
      end else if (do_wr) begin
         value <= nxt;
         pend  <= |nxt;
      end
   end
endmodule

// File: rtl/hostmbox_ipi.sv
module hostmbox_ipi #(
   parameter int unsigned TGT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_wr,
   input  logic             clr_bit,
   input  logic             send_wr,
   input  logic [TGT_W-1:0] send_tgt,
   output logic             pend,
   output logic             req_valid,
   output logic [TGT_W-1:0] req_tgt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         req_valid <= 1'b0;
         req_tgt   <= '0;
      end else begin
         req_valid <= send_wr;
         if (clr_wr)  pend    <= clr_bit;
         if (send_wr) req_tgt <= send_tgt;
      end
   end
endmodule

// File: rtl/hostmbox_regs.sv
module hostmbox_regs
   import hostmbox_pkg::*;
#(
   parameter int unsigned       DATA_W        = 64,
   parameter int unsigned       ADDR_W        = 12,
   parameter int unsigned       TGT_W         = 10,
   parameter bit                HOST_WINS     = 1'b1,
   parameter logic [ADDR_W-1:0] ADDR_OUTBOX   = 12'h7C0,
   parameter logic [ADDR_W-1:0] ADDR_INBOX    = 12'h7C1,
   parameter logic [ADDR_W-1:0] ADDR_IPI_SEND = 12'h7C2,
   parameter logic [ADDR_W-1:0] ADDR_IPI_CLR  = 12'h7C3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_we,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   output logic              csr_hit,
   input  logic              host_out_clr,
   output logic [DATA_W-1:0] host_out_data,
   input  logic              host_in_we,
   input  logic [DATA_W-1:0] host_in_data,
   output logic              irq_host_pend,
   output logic              irq_ipi_pend,
   output logic              ipi_req_valid,
   output logic [TGT_W-1:0]  ipi_req_target
);
   if (TGT_W < 1 || TGT_W > DATA_W) begin : g_bad_tgt
      $error("hostmbox_regs: TGT_W must lie in 1..DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("hostmbox_regs: DATA_W must be at least 2");
   end

   reg_sel_e          sel;
   logic [DATA_W-1:0] outbox_val;
   logic [DATA_W-1:0] inbox_val;
   logic              wr_outbox, wr_inbox, wr_send, wr_clr;

   hostmbox_decode #(
      .ADDR_W       (ADDR_W),
      .ADDR_OUTBOX  (ADDR_OUTBOX),
      .ADDR_INBOX   (ADDR_INBOX),
      .ADDR_IPI_SEND(ADDR_IPI_SEND),
      .ADDR_IPI_CLR (ADDR_IPI_CLR)
   ) u_dec (
      .addr(csr_addr),
      .sel (sel),
      .hit (csr_hit)
   );

   assign wr_outbox = csr_we && (sel == SEL_OUTBOX);
   assign wr_inbox  = csr_we && (sel == SEL_INBOX);
   assign wr_send   = csr_we && (sel == SEL_IPI_SEND);
   assign wr_clr    = csr_we && (sel == SEL_IPI_CLR);

   hostmbox_outbox #(.DATA_W(DATA_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .core_wr   (wr_outbox),
      .core_wdata(csr_wdata),
      .host_clr  (host_out_clr),
      .value     (outbox_val)
   );

   hostmbox_inbox #(.DATA_W(DATA_W), .HOST_WINS(HOST_WINS)) u_in (
      .clk       (clk),
      .rst_n     (rst_n),
      .core_wr   (wr_inbox),
      .core_wdata(csr_wdata),
      .host_wr   (host_in_we),
      .host_wdata(host_in_data),
      .value     (inbox_val),
      .pend      (irq_host_pend)
   );

   hostmbox_ipi #(.TGT_W(TGT_W)) u_ipi (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_wr   (wr_clr),
      .clr_bit  (csr_wdata[0]),
      .send_wr  (wr_send),
      .send_tgt (csr_wdata[TGT_W-1:0]),
      .pend     (irq_ipi_pend),
      .req_valid(ipi_req_valid),
      .req_tgt  (ipi_req_target)
   );

   assign host_out_data = outbox_val;

   always_comb begin
      case (sel)
         SEL_OUTBOX: csr_rdata = outbox_val;
         SEL_INBOX:  csr_rdata = inbox_val;
         default:    csr_rdata = '0;
      endcase
   end
endmodule

// File: rtl/hostmbox_regs_chk.sv
module hostmbox_regs_chk #(
   parameter int unsigned       DATA_W        = 64,
   parameter int unsigned       ADDR_W        = 12,
   parameter logic [ADDR_W-1:0] ADDR_OUTBOX   = 12'h7C0,
   parameter logic [ADDR_W-1:0] ADDR_IPI_SEND = 12'h7C2,
   parameter logic [ADDR_W-1:0] ADDR_IPI_CLR  = 12'h7C3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] csr_addr,
   input logic              csr_we,
   input logic              csr_wbit0,
   input logic [DATA_W-1:0] csr_rdata,
   input logic              host_out_clr,
   input logic [DATA_W-1:0] host_out_data,
   input logic [DATA_W-1:0] inbox_q,
   input logic              irq_host_pend,
   input logic              irq_ipi_pend,
   input logic              ipi_req_valid
);
   logic out_wr, send_wr, clr_wr;
   assign out_wr  = csr_we && (csr_addr == ADDR_OUTBOX);
   assign send_wr = csr_we && (csr_addr == ADDR_IPI_SEND);
   assign clr_wr  = csr_we && (csr_addr == ADDR_IPI_CLR);

   p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_wr && host_out_data != '0 && !host_out_clr) |=> $stable(host_out_data));

   p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      host_out_clr |=> (host_out_data == '0));

   p_pend_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_host_pend == (inbox_q != '0));

   p_clr_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> (irq_ipi_pend == $past(csr_wbit0)));

   p_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == ADDR_IPI_SEND || csr_addr == ADDR_IPI_CLR) |-> (csr_rdata == '0));

   p_send_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      send_wr |=> ipi_req_valid);

   p_no_stray_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !send_wr |=> !ipi_req_valid);
endmodule

bind hostmbox_regs hostmbox_regs_chk #(
   .DATA_W       (DATA_W),
   .ADDR_W       (ADDR_W),
   .ADDR_OUTBOX  (ADDR_OUTBOX),
   .ADDR_IPI_SEND(ADDR_IPI_SEND),
   .ADDR_IPI_CLR (ADDR_IPI_CLR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .csr_addr     (csr_addr),
   .csr_we       (csr_we),
   .csr_wbit0    (csr_wdata[0]),
   .csr_rdata    (csr_rdata),
   .host_out_clr (host_out_clr),
   .host_out_data(host_out_data),
   .inbox_q      (inbox_val),
   .irq_host_pend(irq_host_pend),
   .irq_ipi_pend (irq_ipi_pend),
   .ipi_req_valid(ipi_req_valid)
);

// File: tb/hostmbox_regs_test.sv
module hostmbox_regs_test;
   localparam int DW = 64;
   localparam int AW = 12;
   localparam int TW = 10;
   localparam logic [AW-1:0] A_OUT  = 12'h7C0;
   localparam logic [AW-1:0] A_IN   = 12'h7C1;
   localparam logic [AW-1:0] A_SEND = 12'h7C2;
   localparam logic [AW-1:0] A_CLR  = 12'h7C3;
   localparam logic [AW-1:0] A_BAD  = 12'h100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] csr_addr = '0;
   logic          csr_we = 1'b0;
   logic [DW-1:0] csr_wdata = '0;
   logic [DW-1:0] csr_rdata;
   logic          csr_hit;
   logic          host_out_clr = 1'b0;
   logic [DW-1:0] host_out_data;
   logic          host_in_we = 1'b0;
   logic [DW-1:0] host_in_data = '0;
   logic          irq_host_pend, irq_ipi_pend, ipi_req_valid;
   logic [TW-1:0] ipi_req_target;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [TW-1:0] exp_q[$];

   always #10 clk = ~clk;

   hostmbox_regs uut (
      .clk(clk), .rst_n(rst_n),
      .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .csr_hit(csr_hit),
      .host_out_clr(host_out_clr), .host_out_data(host_out_data),
      .host_in_we(host_in_we), .host_in_data(host_in_data),
      .irq_host_pend(irq_host_pend), .irq_ipi_pend(irq_ipi_pend),
      .ipi_req_valid(ipi_req_valid), .ipi_req_target(ipi_req_target)
   );

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle of stimulus; state is updated by the next negedge
   task automatic cycle(logic we, logic [AW-1:0] a, logic [DW-1:0] d,
                        logic hclr, logic hwe, logic [DW-1:0] hd);
      @(negedge clk);
      csr_we = we; csr_addr = a; csr_wdata = d;
      host_out_clr = hclr; host_in_we = hwe; host_in_data = hd;
      if (we && a == A_SEND) exp_q.push_back(d[TW-1:0]);
      @(negedge clk);
      csr_we = 1'b0; host_out_clr = 1'b0; host_in_we = 1'b0;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      cycle(1'b1, a, d, 1'b0, 1'b0, '0);
   endtask

   task automatic rd_check(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
      csr_addr = a;
      #1;
      check(req, csr_rdata, exp);
   endtask

   // scoreboard monitor for send requests
   always @(negedge clk) begin
      if (rst_n && ipi_req_valid) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R10: actual=pulse target %h expected=no pulse", ipi_req_target);
         end else begin
            logic [TW-1:0] e;
            e = exp_q.pop_front();
            if (ipi_req_target !== e) begin
               bad++;
               $display("FAIL R10: actual=%h expected=%h", ipi_req_target, e);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 outbox", host_out_data, '0);
      check("R1 host irq", {63'd0, irq_host_pend}, '0);
      check("R1 ipi irq", {63'd0, irq_ipi_pend}, '0);
      check("R1 valid", {63'd0, ipi_req_valid}, '0);
      rd_check("R1 inbox read", A_IN, '0);

      // R2 write to empty outbox
      wr(A_OUT, 64'h1234);
      rd_check("R2 read", A_OUT, 64'h1234);
      check("R2 host view", host_out_data, 64'h1234);
      // R3 write to full outbox dropped
      wr(A_OUT, 64'h5555);
      rd_check("R3 hold", A_OUT, 64'h1234);
      // R4 host drain, then drain beating a core write
      cycle(1'b0, A_OUT, '0, 1'b1, 1'b0, '0);
      check("R4 drain", host_out_data, '0);
      wr(A_OUT, 64'h77);
      cycle(1'b1, A_OUT, 64'h99, 1'b1, 1'b0, '0);
      check("R4 drain wins", host_out_data, '0);
      wr(A_OUT, 64'hABC);
      check("R2 refill", host_out_data, 64'hABC);
      cycle(1'b0, A_OUT, '0, 1'b1, 1'b0, '0);

      // R5 / R6 inbound via core
      wr(A_IN, 64'h77);
      rd_check("R5 read", A_IN, 64'h77);
      check("R5 irq", {63'd0, irq_host_pend}, 64'd1);
      wr(A_IN, '0);
      check("R6 irq clear", {63'd0, irq_host_pend}, '0);
      // R7 host load and priority
      cycle(1'b0, A_IN, '0, 1'b0, 1'b1, 64'h9);
      rd_check("R7 host load", A_IN, 64'h9);
      check("R7 irq", {63'd0, irq_host_pend}, 64'd1);
      cycle(1'b1, A_IN, 64'h44, 1'b0, 1'b1, 64'h0);
      rd_check("R7 host wins", A_IN, '0);
      check("R7 irq low", {63'd0, irq_host_pend}, '0);

      // R8 clear-IPI register
      wr(A_CLR, 64'h1);
      check("R8 set", {63'd0, irq_ipi_pend}, 64'd1);
      wr(A_CLR, 64'h2);
      check("R8 clear", {63'd0, irq_ipi_pend}, '0);
      wr(A_CLR, 64'hFFFF_0003);
      check("R8 set again", {63'd0, irq_ipi_pend}, 64'd1);

      // R9 read zero
      rd_check("R9 send reads zero", A_SEND, '0);
      rd_check("R9 clear reads zero", A_CLR, '0);

      // R10 send requests, target masked, back-to-back
      wr(A_SEND, 64'hDEAD_0000_0000_F405);
      @(negedge clk);
      csr_we = 1'b1; csr_addr = A_SEND; csr_wdata = 64'h12;
      exp_q.push_back(10'h12);
      @(negedge clk);
      csr_wdata = 64'h3FF;
      exp_q.push_back(10'h3FF);
      @(negedge clk);
      csr_we = 1'b0;
      repeat (2) @(negedge clk);
      check("R10 queue drained", 64'(exp_q.size()), '0);
      check("R10 valid low", {63'd0, ipi_req_valid}, '0);

      // R11 unmapped address
      csr_addr = A_BAD; #1;
      check("R11 hit", {63'd0, csr_hit}, '0);
      check("R11 rdata", csr_rdata, '0);
      wr(A_BAD, 64'hFF);
      check("R11 outbox untouched", host_out_data, '0);
      rd_check("R11 inbox untouched", A_IN, '0);
      check("R11 no pulse", {63'd0, ipi_req_valid}, '0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule